// File: doc/BRIEF.md
# Asynchronous Coprocessor Bus Slave

This block is the slave end of a coprocessor that sits on a host processor's asynchronous bus. The host starts a transfer with a chip select, an address strobe, a data strobe and a read/write line. A 4-bit register index, taken from address lines A4..A1, picks one of sixteen interface register slots. On a write, the value on the data bus is stored in the chosen slot. On a read, that slot's contents are driven back to the host.

Completion is signalled by a two-bit, active-low transfer-and-size acknowledge. It goes active once the data strobe has been seen during a selected cycle. It then stays active for as long as the host keeps the address strobe asserted, whatever the state of the data strobe. Because the end of the cycle depends only on the strobe, the length of the cycle on the host side does not depend on the slave clock frequency. The only dependence is the fixed synchroniser latency.

All four control inputs are treated as asynchronous. Each is passed through a two-stage synchroniser before use. The register slots here are plain storage, so the handshake can be exercised on its own.

Top module: `cpbus_slave`

## Requirements
- R1: While reset is active and right after it, the acknowledge is 2'b11, the read enable is low, the read data is zero, and every one of the sixteen slots reads back as zero.
- R2: A cycle with chip select, address strobe and data strobe all low and read/write low (0 = write) stores the data bus in the slot indexed by `reg_sel`.
- R3: The acknowledge takes only two codes: 2'b00 for a 32-bit transfer and 2'b11 for none. It becomes 2'b00 on the third clock edge after the data strobe falls in a selected cycle.
- R4: Once the acknowledge is 2'b00, it stays there while the address strobe is held low, even if the data strobe goes high. It returns to 2'b11 on the third clock edge after the address strobe rises.
- R5: A cycle with read/write high (1 = read) drives the indexed slot onto `rdata`. `rdata_oe` is high exactly while the acknowledge of that read is 2'b00.
- R6: With chip select high, strobes get no acknowledge and change no slot.
- R7: While a cycle is held after its acknowledge, a second capture cannot happen. Changing the data bus with both strobes still low leaves the slot at the value taken at acknowledge.
- R8: With chip select and address strobe low but the data strobe high, no acknowledge is given.
- R9: Each of the sixteen slot indices selects its own storage. Writing one slot leaves every other slot unchanged.
- R10: Outside an acknowledged read, `rdata_oe` is low and `rdata` is all zeros, including during write cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| as_n | input | 1 | Address strobe, active low, asynchronous |
| ds_n | input | 1 | Data strobe, active low, asynchronous |
| rd_wr | input | 1 | 1 = read, 0 = write |
| reg_sel | input | 4 | Register slot index (address lines A4..A1) |
| wdata | input | 32 | Data bus value from the host |
| rdata | output | 32 | Read data toward the host, zero when released |
| rdata_oe | output | 1 | Data bus drive enable |
| ack_n | output | 2 | Transfer-and-size acknowledge, active low |

## Verification
Writes and reads are applied with three data-strobe widths. In the first, the strobe is released right after the acknowledge. In the second, it is held for several clocks. In the third, it is held until the address strobe rises. Together these show that the acknowledge follows the address strobe and not the data strobe. Negative patterns, with chip select absent or the data strobe absent, separate "selected" from "strobed". A data bus that changes while both strobes are held separates a single capture from repeated captures. Walking distinct values across all sixteen indices, then reading them back, exposes any aliasing in the slot decode.

// File: rtl/cpbus_pkg.sv
package cpbus_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_ACK  = 1'b1
  } cp_state_t;

  localparam logic [1:0] ACK_PORT32 = 2'b00;
  localparam logic [1:0] ACK_NONE   = 2'b11;
endpackage

// File: rtl/cpbus_sync.sv
module cpbus_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  always_comb begin
    chain_d[0] = d_async;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cpbus_ctrl.sv
module cpbus_ctrl
  import cpbus_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_s,
  input  logic          astb_s,
  input  logic          dstb_s,
  input  logic          rd_s,
  input  logic [AW-1:0] idx_in,
  output logic          wr_en,
  output logic [AW-1:0] idx_q,
  output logic          ack_act,
  output logic          rd_act
);
  cp_state_t     state_q, state_d;
  logic          rd_q, rd_d;
  logic [AW-1:0] idx_d;
  logic          start;
  logic          lat_en;

  always_comb begin
    start   = (state_q == ST_IDLE) && sel_s && astb_s && dstb_s;
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_ACK;
      ST_ACK:  if (!astb_s) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    lat_en = start;
    rd_d   = lat_en ? rd_s : rd_q;
    idx_d  = lat_en ? idx_in : idx_q;
    wr_en  = start && !rd_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rd_q    <= 1'b0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (lat_en) begin
        rd_q  <= rd_d;
        idx_q <= idx_d;
      end
    end
  end

  assign ack_act = (state_q == ST_ACK);
  assign rd_act  = ack_act && rd_q;
endmodule

// File: rtl/cpbus_regfile.sv
module cpbus_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [NREG-1:0][DW-1:0] slot_q;

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_idx == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (slot_en) begin
        slot_q[g] <= wr_data;
      end
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/cpbus_slave.sv
module cpbus_slave
  import cpbus_pkg::*;
#(
  parameter int DW       = 32,
  parameter int NREG     = 16,
  parameter int SYNC_LEN = 2,
  localparam int AW      = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          as_n,
  input  logic          ds_n,
  input  logic          rd_wr,
  input  logic [AW-1:0] reg_sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe,
  output logic [1:0]    ack_n
);
  logic [3:0]    ctl_s;
  logic          wr_en;
  logic [AW-1:0] idx_q;
  logic          ack_act;
  logic          rd_act;
  logic [DW-1:0] slot_data;

  cpbus_sync #(.W(4), .STAGES(SYNC_LEN), .RST_VAL(4'b1111)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({cs_n, as_n, ds_n, rd_wr}),
    .q_sync  (ctl_s)
  );

  cpbus_ctrl #(.AW(AW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_s   (~ctl_s[3]),
    .astb_s  (~ctl_s[2]),
    .dstb_s  (~ctl_s[1]),
    .rd_s    (ctl_s[0]),
    .idx_in  (reg_sel),
    .wr_en   (wr_en),
    .idx_q   (idx_q),
    .ack_act (ack_act),
    .rd_act  (rd_act)
  );

  cpbus_regfile #(.DW(DW), .NREG(NREG)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (reg_sel),
    .wr_data (wdata),
    .rd_idx  (idx_q),
    .rd_data (slot_data)
  );

  assign ack_n    = ack_act ? ACK_PORT32 : ACK_NONE;
  assign rdata_oe = rd_act;
  assign rdata    = rd_act ? slot_data : '0;
endmodule

// File: rtl/cpbus_slave_chk.sv
module cpbus_slave_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          as_n,
  input logic          wr_en,
  input logic [DW-1:0] rdata,
  input logic          rdata_oe,
  input logic [1:0]    ack_n
);
  logic [1:0] warm_q;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end
  assign warm = (warm_q == 2'd3);

  // R3: only the two legal acknowledge codes
  a_r3_ack_code: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_n == 2'b00) || (ack_n == 2'b11));

  // R10: drive enable only inside an acknowledge
  a_r10_oe_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> (ack_n == 2'b00));

  // R10: released bus carries zeros
  a_r10_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> (rdata == '0));

  // R6: no new acknowledge without chip select
  a_r6_no_sel_no_ack: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    ((ack_n == 2'b11) && $past(cs_n, 2)) |=> (ack_n == 2'b11));

  // R4: acknowledge held while address strobe stays low
  a_r4_hold_on_as: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    ((ack_n == 2'b00) && !$past(as_n, 2)) |=> (ack_n == 2'b00));

  // R7: one capture per cycle
  a_r7_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R2: every capture is followed by an acknowledge
  a_r2_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ack_n == 2'b00));
endmodule

bind cpbus_slave cpbus_slave_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .as_n     (as_n),
  .wr_en    (wr_en),
  .rdata    (rdata),
  .rdata_oe (rdata_oe),
  .ack_n    (ack_n)
);

// File: tb/cpbus_slave_tb.sv
module cpbus_slave_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, as_n, ds_n, rd_wr;
  logic [3:0]  reg_sel;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        rdata_oe;
  logic [1:0]  ack_n;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    cycles  = 0;
  bit    done    = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  cpbus_slave dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .as_n(as_n), .ds_n(ds_n),
    .rd_wr(rd_wr), .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata),
    .rdata_oe(rdata_oe), .ack_n(ack_n)
  );

  // ---------------- behavioural reference model ----------------
  typedef struct packed { logic sel; logic astb; logic dstb; logic rd; } strb_t;
  strb_t       hist[$];
  logic [31:0] m_mem [16];
  bit          m_ack, m_rd;
  int          m_idx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{strb_t'(4'b0000), strb_t'(4'b0000)};
      foreach (m_mem[i]) m_mem[i] = '0;
      m_ack = 0; m_rd = 0; m_idx = 0;
    end else begin
      strb_t s;
      hist.push_back('{sel: !cs_n, astb: !as_n, dstb: !ds_n, rd: rd_wr});
      s = hist.pop_front();
      if (!m_ack && s.sel && s.astb && s.dstb) begin
        m_ack = 1; m_rd = s.rd; m_idx = int'(reg_sel);
        if (!s.rd) m_mem[reg_sel] = wdata;
      end else if (m_ack && !s.astb) begin
        m_ack = 0;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, " ack"},  32'(ack_n),    m_ack ? 32'h0 : 32'h3);
      chk({cur_req, " oe"},   32'(rdata_oe), 32'(m_ack && m_rd));
      chk({cur_req, " data"}, rdata,         (m_ack && m_rd) ? m_mem[m_idx] : 32'h0);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected < 50000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  // ds_hold: negedges the data strobe stays low after acknowledge (-1 = until AS rises)
  task automatic bus_cycle(input bit rd, input logic [3:0] idx, input logic [31:0] d,
                           input int ds_hold, input int as_hold, output logic [31:0] got);
    int lat;
    @(negedge clk); cs_n = 0; as_n = 0; rd_wr = rd; reg_sel = idx; wdata = d;
    @(negedge clk); ds_n = 0;
    lat = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); lat++;
      if (ack_n == 2'b00) break;
    end
    chk({cur_req, " R3 ack latency"}, 32'(lat), 32'd3);
    got = rdata;
    if (rd) chk({cur_req, " R5 oe in read ack"}, 32'(rdata_oe), 32'd1);
    else    chk({cur_req, " R10 oe low in write"}, 32'(rdata_oe), 32'd0);
    for (int k = 0; k < ds_hold; k++) @(negedge clk);
    if (ds_hold >= 0) ds_n = 1;
    for (int k = 0; k < as_hold; k++) begin
      @(negedge clk);
      chk({cur_req, " R4 ack held on AS"}, 32'(ack_n), 32'h0);
    end
    as_n = 1; cs_n = 1; ds_n = 1;
    lat = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); lat++;
      if (ack_n == 2'b11) break;
    end
    chk({cur_req, " R4 release latency"}, 32'(lat), 32'd3);
    chk({cur_req, " R5 oe after release"}, 32'(rdata_oe), 32'd0);
  endtask

  logic [31:0] got;

  initial begin
    rst_n = 0; cs_n = 1; as_n = 1; ds_n = 1; rd_wr = 1; reg_sel = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 ack in reset", 32'(ack_n), 32'h3);
    chk("R1 oe in reset", 32'(rdata_oe), 32'h0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 data after reset", rdata, 32'h0);

    cur_req = "R1";
    for (int i = 0; i < 16; i++) begin
      bus_cycle(1'b1, 4'(i), 32'h0, 0, 1, got);
      chk("R1 slot zero", got, 32'h0);
    end

    cur_req = "R2";
    bus_cycle(1'b0, 4'd5, 32'hCAFE_0005, 0, 1, got);
    bus_cycle(1'b1, 4'd5, 32'h0, 0, 1, got);
    chk("R2/R5 readback", got, 32'hCAFE_0005);

    cur_req = "R4";
    bus_cycle(1'b0, 4'd9, 32'h1234_5678, 0, 6, got);
    bus_cycle(1'b1, 4'd9, 32'h0, 4, 3, got);
    chk("R4 readback", got, 32'h1234_5678);
    bus_cycle(1'b1, 4'd9, 32'h0, -1, 5, got);
    chk("R4/R5 long strobe read", got, 32'h1234_5678);

    cur_req = "R9";
    for (int i = 0; i < 16; i++) bus_cycle(1'b0, 4'(i), 32'hA500_0000 | 32'(i * 17), 1, 0, got);
    for (int i = 15; i >= 0; i--) begin
      bus_cycle(1'b1, 4'(i), 32'h0, 0, 0, got);
      chk("R9 slot distinct", got, 32'hA500_0000 | 32'(i * 17));
    end

    cur_req = "R6";
    @(negedge clk); cs_n = 1; as_n = 0; ds_n = 0; rd_wr = 0; reg_sel = 4'd3; wdata = 32'hDEAD_BEEF;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R6 no ack without select", 32'(ack_n), 32'h3);
    end
    as_n = 1; ds_n = 1;
    repeat (3) @(negedge clk);
    bus_cycle(1'b1, 4'd3, 32'h0, 0, 0, got);
    chk("R6 slot unchanged", got, 32'hA500_0033);

    cur_req = "R8";
    @(negedge clk); cs_n = 0; as_n = 0; ds_n = 1; rd_wr = 0; reg_sel = 4'd4; wdata = 32'h0BAD_0BAD;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R8 no ack without data strobe", 32'(ack_n), 32'h3);
    end
    cs_n = 1; as_n = 1;
    repeat (3) @(negedge clk);
    bus_cycle(1'b1, 4'd4, 32'h0, 0, 0, got);
    chk("R8 slot unchanged", got, 32'hA500_0044);

    cur_req = "R7";
    @(negedge clk); cs_n = 0; as_n = 0; rd_wr = 0; reg_sel = 4'd7; wdata = 32'h7777_0001;
    @(negedge clk); ds_n = 0;
    repeat (3) @(negedge clk);
    chk("R7 ack before data change", 32'(ack_n), 32'h0);
    wdata = 32'h7777_0002;
    repeat (5) @(negedge clk);
    as_n = 1; cs_n = 1; ds_n = 1;
    repeat (4) @(negedge clk);
    bus_cycle(1'b1, 4'd7, 32'h0, 0, 0, got);
    chk("R7 single capture", got, 32'h7777_0001);

    cur_req = "R10";
    bus_cycle(1'b0, 4'd0, 32'hFFFF_FFFF, 2, 2, got);
    chk("R10 data released in write", got, 32'h0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule